// File: doc/BRIEF.md
# Two-Thread Memory-Order Queue with Tag-Only Overflow Slots

This block holds the memory operations of a two-thread core in program order, one queue per thread. Each thread owns a set of real slots that can hold an address and a further set of overflow slots that hold only the instruction tag. Dispatch keeps flowing while either kind of slot is free. When the oldest operation of a thread retires, the oldest tag-only operation of that thread moves into a real slot, and its tag is announced so that address generation for it can go ahead.

Addresses arrive later, by tag, and are only accepted for operations that already sit in a real slot. A conflict probe compares a line address against the written addresses of the same thread's real slots that are older than the probing operation, and returns a hit flag. In solo mode the second thread is idle and the first thread gets the capacity of both.

Top module: `rq_virt_queue`

## Requirements
- R1: After reset both queues are empty, `disp_rdy` is 2'b11, and `prom_vld`, `aw_ack`, `aw_retry` and `chk_hit` are all low.
- R2: In split mode (`st_mode`=0) a thread accepts one dispatch per cycle while it holds fewer than REAL_N+VIRT_N (32) operations. `disp_rdy[t]` goes low once it holds 32 and is high again the cycle after a retire frees space. Bit t of the dispatch ports belongs to thread t, with its tag in `disp_tag[t*TAG_W +: TAG_W]`.
- R3: The oldest REAL_N (16) operations of a thread occupy real slots. An address write naming one of their tags is answered by `aw_ack` high one cycle later.
- R4: `ret_vld[t]` retires the oldest operation of thread t. Each thread retires at most one per cycle, operations leave in dispatch order, and a retire request on an empty thread is ignored.
- R5: When a retire removes an operation while the thread also holds tag-only operations, `prom_vld[t]` rises one cycle later and `prom_tag` carries the tag of the oldest tag-only operation, which from then on counts as real.
- R6: An address write whose tag is not held in a real slot of thread `aw_thr` is answered by `aw_retry` high one cycle later. No address is stored, so later probes do not see it. `aw_ack` and `aw_retry` are never high together.
- R7: One cycle after `chk_vld`, `chk_hit` is high if and only if some real slot of thread `chk_thr` has a written address with the same line (address bits above LINE_LSB) and is older than the slot holding `chk_tag`. If `chk_tag` is not held in a real slot, every real slot of that thread counts as older.
- R8: The two threads in split mode are independent. Dispatch, retire, address writes and probes on one thread never change the occupancy or the results of the other.
- R9: In solo mode (`st_mode`=1) thread 0 holds up to 64 operations, of which the oldest 32 are real. `disp_rdy[1]` is low, and dispatch and retire on thread 1 are ignored. The mode may change only while both threads are empty and no dispatch is presented. `disp_rdy` follows the new mode one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_mode | input | 1 | 1 = solo mode, 0 = split mode |
| disp_vld | input | 2 | Dispatch request per thread |
| disp_tag | input | 2*TAG_W | Dispatch tag per thread |
| disp_rdy | output | 2 | Thread can accept a dispatch (registered) |
| ret_vld | input | 2 | Retire oldest operation per thread |
| aw_vld | input | 1 | Address write request |
| aw_thr | input | 1 | Thread of the address write |
| aw_tag | input | TAG_W | Tag of the operation being given an address |
| aw_addr | input | ADDR_W | Byte address |
| aw_ack | output | 1 | Address stored |
| aw_retry | output | 1 | Tag not in a real slot, try again later |
| chk_vld | input | 1 | Conflict probe request |
| chk_thr | input | 1 | Thread probed |
| chk_tag | input | TAG_W | Tag of the probing operation |
| chk_addr | input | ADDR_W | Byte address probed |
| chk_hit | output | 1 | Older same-thread line match found |
| prom_vld | output | 2 | Tag-only operation became real, per thread |
| prom_tag | output | 2*TAG_W | Tag of the promoted operation, per thread |

## Verification
The bench uses the default sizes: 16 real and 16 tag-only slots per thread, 8-bit tags and 64-byte lines. With these sizes a burst of about forty dispatch-heavy cycles fills a thread, which brings the stall, the tag-only region and a run of back-to-back promotions within reach of short directed phases. Probe and write addresses are drawn from only four lines, so line hits, hits masked by the probing operation's own age, and retries on overflow tags all occur often in the random phases. The solo phase fills thread 0 to its doubled capacity of 64 while thread 1 is being driven.

// File: rtl/rq_pkg.sv
package rq_pkg;
  localparam int NTHR = 2;
  typedef enum logic {
    MODE_SPLIT = 1'b0,
    MODE_SOLO  = 1'b1
  } rq_mode_e;
endpackage

// File: rtl/rq_thread_ctl.sv
module rq_thread_ctl #(
  parameter int REAL_N = 16,
  parameter int TOT_N  = 32,
  parameter int THR    = 0,
  localparam int PW    = $clog2(2*TOT_N),
  localparam int CW    = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          solo,
  input  logic          disp_vld,
  input  logic          ret_vld,
  output logic [PW-1:0] head,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] rcnt,
  output logic [PW-1:0] tail,
  output logic [PW-1:0] pptr,
  output logic          disp_fire,
  output logic          ret_fire,
  output logic          prom_fire,
  output logic          disp_rdy
);
  logic [CW-1:0] cap, rcap, cnt_nx;

  function automatic logic [PW-1:0] padd(input logic s, input logic [PW-1:0] a,
                                         input logic [PW-1:0] b);
    logic [PW-1:0] sum;
    sum = a + b;
    return s ? sum : {1'b0, sum[PW-2:0]};
  endfunction

  always_comb begin
    if (solo) begin
      cap  = (THR == 0) ? CW'(2*TOT_N)  : '0;
      rcap = (THR == 0) ? CW'(2*REAL_N) : '0;
    end else begin
      cap  = CW'(TOT_N);
      rcap = CW'(REAL_N);
    end
  end

  assign disp_fire = disp_vld & disp_rdy;
  assign ret_fire  = ret_vld && (cnt != '0);
  assign prom_fire = ret_fire && (cnt > rcap);
  assign rcnt      = (cnt < rcap) ? cnt : rcap;
  assign tail      = padd(solo, head, cnt[PW-1:0]);
  assign pptr      = padd(solo, head, rcap[PW-1:0]);
  assign cnt_nx    = cnt + CW'(disp_fire) - CW'(ret_fire);

  always_ff @(posedge clk) begin
    if (rst) begin
      head     <= '0;
      cnt      <= '0;
      disp_rdy <= (cap != '0);
    end else begin
      if (ret_fire) head <= padd(solo, head, PW'(1));
      cnt      <= cnt_nx;
      disp_rdy <= (cnt_nx < cap);
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst) cnt <= cap);
  p_rdy_room_r2:  assert property (@(posedge clk) disable iff (rst)
                    disp_rdy && $stable(solo) |-> cnt < cap);
  p_head_hold_r4: assert property (@(posedge clk) disable iff (rst)
                    !ret_vld |=> $stable(head));
  generate
    if (THR == 1) begin : g_t1
      p_solo_idle_r9: assert property (@(posedge clk) disable iff (rst)
                        solo && $past(solo) |-> !disp_rdy);
    end
  endgenerate
endmodule

// File: rtl/rq_scan.sv
module rq_scan #(
  parameter int TAG_W = 8,
  parameter int LW    = 26,
  parameter int WN    = 32,
  parameter int CW    = 7,
  localparam int KW   = $clog2(WN)
) (
  input  logic [TAG_W-1:0] win_tag [WN],
  input  logic [LW-1:0]    win_line [WN],
  input  logic [WN-1:0]    win_av,
  input  logic [CW-1:0]    rcnt,
  input  logic [TAG_W-1:0] key_tag,
  input  logic [LW-1:0]    key_line,
  output logic             found,
  output logic [KW-1:0]    found_k,
  output logic             hit_older
);
  always_comb begin
    found     = 1'b0;
    found_k   = '0;
    hit_older = 1'b0;
    for (int k = 0; k < WN; k++) begin
      if (CW'(k) < rcnt && !found) begin
        if (win_tag[k] == key_tag) begin
          found   = 1'b1;
          found_k = KW'(k);
        end else if (win_av[k] && win_line[k] == key_line) begin
          hit_older = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rq_virt_queue.sv
module rq_virt_queue
  import rq_pkg::*;
#(
  parameter int TAG_W    = 8,
  parameter int ADDR_W   = 32,
  parameter int LINE_LSB = 6,
  parameter int REAL_N   = 16,
  parameter int VIRT_N   = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 st_mode,
  input  logic [1:0]           disp_vld,
  input  logic [2*TAG_W-1:0]   disp_tag,
  output logic [1:0]           disp_rdy,
  input  logic [1:0]           ret_vld,
  input  logic                 aw_vld,
  input  logic                 aw_thr,
  input  logic [TAG_W-1:0]     aw_tag,
  input  logic [ADDR_W-1:0]    aw_addr,
  output logic                 aw_ack,
  output logic                 aw_retry,
  input  logic                 chk_vld,
  input  logic                 chk_thr,
  input  logic [TAG_W-1:0]     chk_tag,
  input  logic [ADDR_W-1:0]    chk_addr,
  output logic                 chk_hit,
  output logic [1:0]           prom_vld,
  output logic [2*TAG_W-1:0]   prom_tag
);
  localparam int TOT_N = REAL_N + VIRT_N;
  localparam int PW    = $clog2(2*TOT_N);
  localparam int CW    = PW + 1;
  localparam int WN    = 2*REAL_N;
  localparam int AIW   = $clog2(WN);
  localparam int LW    = ADDR_W - LINE_LSB;

  rq_mode_e mode;
  logic     solo;
  assign mode = rq_mode_e'(st_mode);
  assign solo = (mode == MODE_SOLO);

  logic [TAG_W-1:0] tag_mem  [2*TOT_N];
  logic [LW-1:0]    line_mem [WN];
  logic [WN-1:0]    av;

  logic [PW-1:0] head [NTHR];
  logic [PW-1:0] tail [NTHR];
  logic [PW-1:0] pptr [NTHR];
  logic [CW-1:0] cnt  [NTHR];
  logic [CW-1:0] rcnt [NTHR];
  logic [NTHR-1:0] d_fire, r_fire, p_fire, rdy_w;

  function automatic logic [PW-1:0] padd(input logic s, input logic [PW-1:0] a,
                                         input logic [PW-1:0] b);
    logic [PW-1:0] sum;
    sum = a + b;
    return s ? sum : {1'b0, sum[PW-2:0]};
  endfunction
  function automatic logic [PW-1:0] tidx(input logic s, input logic t, input logic [PW-1:0] p);
    return s ? p : {t, p[PW-2:0]};
  endfunction
  function automatic logic [AIW-1:0] aidx(input logic s, input logic t, input logic [PW-1:0] p);
    return s ? p[AIW-1:0] : {t, p[AIW-2:0]};
  endfunction

  logic [TAG_W-1:0] win_tag  [NTHR][WN];
  logic [LW-1:0]    win_line [NTHR][WN];
  logic [WN-1:0]    win_av   [NTHR];

  generate
    for (genvar t = 0; t < NTHR; t++) begin : g_thr
      rq_thread_ctl #(.REAL_N(REAL_N), .TOT_N(TOT_N), .THR(t)) ctl_i (
        .clk(clk), .rst(rst), .solo(solo),
        .disp_vld(disp_vld[t]), .ret_vld(ret_vld[t]),
        .head(head[t]), .cnt(cnt[t]), .rcnt(rcnt[t]), .tail(tail[t]), .pptr(pptr[t]),
        .disp_fire(d_fire[t]), .ret_fire(r_fire[t]), .prom_fire(p_fire[t]),
        .disp_rdy(rdy_w[t])
      );
      for (genvar k = 0; k < WN; k++) begin : g_win
        logic [PW-1:0] wpos;
        assign wpos           = padd(solo, head[t], PW'(k));
        assign win_tag[t][k]  = tag_mem[tidx(solo, 1'(t), wpos)];
        assign win_line[t][k] = line_mem[aidx(solo, 1'(t), wpos)];
        assign win_av[t][k]   = av[aidx(solo, 1'(t), wpos)];
      end
    end
  endgenerate
  assign disp_rdy = rdy_w;

  // scanner 0 serves address writes, scanner 1 serves conflict probes
  logic [NTHR-1:0] sc_found, sc_hit;
  logic [AIW-1:0]  sc_fk [NTHR];
  generate
    for (genvar sc = 0; sc < 2; sc++) begin : g_scan
      logic             s_thr;
      logic [TAG_W-1:0] s_tag [WN];
      logic [LW-1:0]    s_line [WN];
      logic [TAG_W-1:0] k_tag;
      logic [LW-1:0]    k_line;
      assign s_thr  = (sc == 0) ? aw_thr : chk_thr;
      assign k_tag  = (sc == 0) ? aw_tag : chk_tag;
      assign k_line = (sc == 0) ? aw_addr[ADDR_W-1:LINE_LSB] : chk_addr[ADDR_W-1:LINE_LSB];
      always_comb begin
        for (int k = 0; k < WN; k++) begin
          s_tag[k]  = win_tag[s_thr][k];
          s_line[k] = win_line[s_thr][k];
        end
      end
      rq_scan #(.TAG_W(TAG_W), .LW(LW), .WN(WN), .CW(CW)) scan_i (
        .win_tag(s_tag), .win_line(s_line), .win_av(win_av[s_thr]),
        .rcnt(rcnt[s_thr]), .key_tag(k_tag), .key_line(k_line),
        .found(sc_found[sc]), .found_k(sc_fk[sc]), .hit_older(sc_hit[sc])
      );
    end
  endgenerate

  logic side_unused;
  assign side_unused = ^{sc_fk[1], sc_found[1], sc_hit[0],
                         aw_addr[LINE_LSB-1:0], chk_addr[LINE_LSB-1:0]};

  logic [AIW-1:0] aw_ai;
  logic           aw_take;
  assign aw_ai   = aidx(solo, aw_thr, padd(solo, head[aw_thr], PW'(sc_fk[0])));
  assign aw_take = aw_vld && sc_found[0];

  always_ff @(posedge clk) begin
    for (int t = 0; t < NTHR; t++)
      if (d_fire[t]) tag_mem[tidx(solo, 1'(t), tail[t])] <= disp_tag[t*TAG_W +: TAG_W];
    if (aw_take) line_mem[aw_ai] <= aw_addr[ADDR_W-1:LINE_LSB];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      av <= '0;
    end else begin
      if (aw_take) av[aw_ai] <= 1'b1;
      for (int t = 0; t < NTHR; t++)
        if (r_fire[t]) av[aidx(solo, 1'(t), head[t])] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_ack   <= 1'b0;
      aw_retry <= 1'b0;
      chk_hit  <= 1'b0;
      prom_vld <= '0;
      prom_tag <= '0;
    end else begin
      aw_ack   <= aw_take;
      aw_retry <= aw_vld && !sc_found[0];
      chk_hit  <= chk_vld && sc_hit[1];
      prom_vld <= p_fire;
      for (int t = 0; t < NTHR; t++)
        if (p_fire[t]) prom_tag[t*TAG_W +: TAG_W] <= tag_mem[tidx(solo, 1'(t), pptr[t])];
    end
  end

  p_ack_excl_r6:   assert property (@(posedge clk) disable iff (rst) !(aw_ack && aw_retry));
  p_ack_cause_r3:  assert property (@(posedge clk) disable iff (rst)
                     (aw_ack || aw_retry) |-> $past(aw_vld));
  p_hit_cause_r7:  assert property (@(posedge clk) disable iff (rst) chk_hit |-> $past(chk_vld));
  p_prom0_cause_r5: assert property (@(posedge clk) disable iff (rst)
                      prom_vld[0] |-> $past(ret_vld[0]));
  p_prom1_cause_r5: assert property (@(posedge clk) disable iff (rst)
                      prom_vld[1] |-> $past(ret_vld[1]));
  p_mode_quiet_r9: assert property (@(posedge clk) disable iff (rst)
                     !$stable(st_mode) |-> (cnt[0] == '0 && cnt[1] == '0));
endmodule

// File: tb/rq_virt_queue_tb_top.sv
module rq_virt_queue_tb_top;
  localparam int TAG_W = 8, ADDR_W = 32, LINE_LSB = 6, REAL_N = 16, VIRT_N = 16;

  logic clk = 1'b0, rst = 1'b1, st_mode = 1'b0;
  logic [1:0] disp_vld = '0, ret_vld = '0;
  logic [2*TAG_W-1:0] disp_tag = '0;
  logic [1:0] disp_rdy, prom_vld;
  logic [2*TAG_W-1:0] prom_tag;
  logic aw_vld = 1'b0, aw_thr = 1'b0, chk_vld = 1'b0, chk_thr = 1'b0;
  logic [TAG_W-1:0] aw_tag = '0, chk_tag = '0;
  logic [ADDR_W-1:0] aw_addr = '0, chk_addr = '0;
  logic aw_ack, aw_retry, chk_hit;

  always #10 clk = ~clk;

  rq_virt_queue #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .LINE_LSB(LINE_LSB),
                  .REAL_N(REAL_N), .VIRT_N(VIRT_N)) dut_i (
    .clk(clk), .rst(rst), .st_mode(st_mode),
    .disp_vld(disp_vld), .disp_tag(disp_tag), .disp_rdy(disp_rdy), .ret_vld(ret_vld),
    .aw_vld(aw_vld), .aw_thr(aw_thr), .aw_tag(aw_tag), .aw_addr(aw_addr),
    .aw_ack(aw_ack), .aw_retry(aw_retry),
    .chk_vld(chk_vld), .chk_thr(chk_thr), .chk_tag(chk_tag), .chk_addr(chk_addr),
    .chk_hit(chk_hit), .prom_vld(prom_vld), .prom_tag(prom_tag)
  );

  int checks = 0, errs = 0;
  int mc [2];
  logic [7:0]  mt  [2][64];
  bit          mav [2][64];
  logic [25:0] ml  [2][64];
  int seq [2];
  bit st = 1'b0;

  function automatic int capf(int t);
    return st ? ((t == 0) ? 64 : 0) : 32;
  endfunction
  function automatic int rcapf(int t);
    return st ? ((t == 0) ? 32 : 0) : 16;
  endfunction

  task automatic chk1(input string r, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", r, a, e);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  endtask

  task automatic cyc(input int pd, input int pr, input bit en_aw, input bit en_chk);
    bit dv [2];
    bit rv [2];
    bit df [2];
    bit rf [2];
    bit ep [2];
    logic [7:0] ept [2];
    bit awv, cv, awfound, ehit, cfound;
    int awt, ct, awk;
    logic [7:0] awtag, ctag;
    logic [31:0] awaddr, caddr;
    @(negedge clk);
    for (int t = 0; t < 2; t++) begin
      dv[t] = ($urandom % 100) < pd;
      rv[t] = ($urandom % 100) < pr;
    end
    awv = en_aw && ($urandom % 2 == 0);
    awt = st ? 0 : int'($urandom % 2);
    if (mc[awt] > 0 && $urandom % 4 != 0) awtag = mt[awt][$urandom % mc[awt]];
    else awtag = 8'($urandom);
    awaddr = 32'(($urandom % 4) * 64 + ($urandom % 64));
    cv = en_chk && ($urandom % 2 == 0);
    ct = st ? 0 : int'($urandom % 2);
    if (mc[ct] > 0 && $urandom % 4 != 0) ctag = mt[ct][$urandom % mc[ct]];
    else ctag = 8'($urandom);
    caddr = 32'(($urandom % 4) * 64 + ($urandom % 64));
    for (int t = 0; t < 2; t++) begin
      disp_vld[t] = dv[t];
      ret_vld[t]  = rv[t];
      disp_tag[t*8 +: 8] = 8'(seq[t]);
    end
    aw_vld = awv; aw_thr = 1'(awt); aw_tag = awtag; aw_addr = awaddr;
    chk_vld = cv; chk_thr = 1'(ct); chk_tag = ctag; chk_addr = caddr;
    // expectations from the state before this edge
    awfound = 1'b0; awk = 0;
    for (int k = 0; k < mc[awt] && k < rcapf(awt); k++)
      if (!awfound && mt[awt][k] == awtag) begin awfound = 1'b1; awk = k; end
    ehit = 1'b0; cfound = 1'b0;
    for (int k = 0; k < mc[ct] && k < rcapf(ct); k++) begin
      if (!cfound) begin
        if (mt[ct][k] == ctag) cfound = 1'b1;
        else if (mav[ct][k] && ml[ct][k] == caddr[31:6]) ehit = 1'b1;
      end
    end
    for (int t = 0; t < 2; t++) begin
      df[t]  = dv[t] && mc[t] < capf(t);
      rf[t]  = rv[t] && mc[t] > 0;
      ep[t]  = rf[t] && mc[t] > rcapf(t);
      ept[t] = mt[t][rcapf(t)];
    end
    // model update
    if (awv && awfound) begin mav[awt][awk] = 1'b1; ml[awt][awk] = awaddr[31:6]; end
    for (int t = 0; t < 2; t++) begin
      if (rf[t]) begin
        for (int k = 0; k < 63; k++) begin
          mt[t][k] = mt[t][k+1]; mav[t][k] = mav[t][k+1]; ml[t][k] = ml[t][k+1];
        end
        mc[t]--;
      end
      if (df[t]) begin
        mt[t][mc[t]] = 8'(seq[t]); mav[t][mc[t]] = 1'b0;
        mc[t]++; seq[t]++;
      end
    end
    @(posedge clk); #1;
    for (int t = 0; t < 2; t++) begin
      chk1(st ? "R9 disp_rdy" : ((t == 0) ? "R2 disp_rdy" : "R8 disp_rdy"),
           32'(disp_rdy[t]), 32'(mc[t] < capf(t)));
      chk1("R5 prom_vld", 32'(prom_vld[t]), 32'(ep[t]));
      if (ep[t]) chk1("R4 prom_tag order", 32'(prom_tag[t*8 +: 8]), 32'(ept[t]));
    end
    chk1("R3 aw_ack", 32'(aw_ack), 32'(awv && awfound));
    chk1("R6 aw_retry", 32'(aw_retry), 32'(awv && !awfound));
    chk1("R7 chk_hit", 32'(chk_hit), 32'(cv && ehit));
  endtask

  task automatic set_mode(input bit m);
    @(negedge clk);
    disp_vld = '0; ret_vld = '0; aw_vld = 1'b0; chk_vld = 1'b0;
    st_mode = m; st = m;
    @(posedge clk); #1;
    for (int t = 0; t < 2; t++)
      chk1("R9 mode switch rdy", 32'(disp_rdy[t]), 32'(mc[t] < capf(t)));
  endtask

  initial begin
    #(20 * 200000);
    checks++; errs++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int t = 0; t < 2; t++) begin mc[t] = 0; seq[t] = t * 100; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    chk1("R1 disp_rdy", 32'(disp_rdy), 32'h3);
    chk1("R1 prom_vld", 32'(prom_vld), 32'h0);
    chk1("R1 aw_ack", 32'(aw_ack), 32'h0);
    chk1("R1 aw_retry", 32'(aw_retry), 32'h0);
    chk1("R1 chk_hit", 32'(chk_hit), 32'h0);
    // fill both threads past capacity, then drain through promotions
    repeat (40) cyc(100, 0, 1, 1);
    repeat (40) cyc(0, 100, 1, 1);
    repeat (3000) cyc(55, 45, 1, 1);
    repeat (70) cyc(0, 100, 0, 0);
    // solo mode
    set_mode(1'b1);
    repeat (80) cyc(100, 0, 1, 1);
    repeat (80) cyc(0, 100, 1, 1);
    repeat (2000) cyc(55, 45, 1, 1);
    repeat (80) cyc(0, 100, 0, 0);
    set_mode(1'b0);
    repeat (500) cyc(60, 40, 1, 1);
    summary();
  end
endmodule